// File: doc/BRIEF.md
# Interrupt Priority Level Resolver

This block turns the pending interrupt sources of a processor pipeline into one priority level and a summary mask. It then decides whether that level is high enough to interrupt the running code. Two request vectors feed it. The first holds software-raised requests, and each of its bits maps to a level counted from the bottom of its scan window. The second holds external interrupt lines, and each of their bits carries its own index as its level. If any external line in its window is pending, the external result is used in place of the software result. Within each group, the highest pending bit decides the level.

An evaluation takes place only when the pipeline control signals that an interrupt is pending, or when an earlier request is still waiting.
- If the pipeline still holds instructions, the block sets a blocked flag and waits for it to drain.
- If the pipeline is empty but the two low program-counter bits are nonzero (privileged execution), the request is dropped for that cycle.
- Otherwise the level is compared with the current priority level. If the level is strictly higher, the summary and level registers are written and a one-cycle squash request is raised so that the pipeline can redirect.

An asynchronous-trap request seen during an evaluation is not serviced. It raises an error flag instead.

Top module: `irq_level_resolver`

## Requirements
- R1: A software request bit i inside the window SW_MIN..SW_MAX-1 (defaults 1..15) gives level i-SW_MIN+1. When several are pending, the highest index decides the level.
- R2: An external bit i inside EXT_MIN..EXT_MAX-1 (defaults 16..31) gives level i, and the highest pending index decides. Any pending external bit in its window overrides the software level.
- R3: The summary mask has a 1 at the position of every pending bit that lies inside either window, taken from the request vector that holds it. Bits outside both windows have no effect on the level or on the summary.
- R4: An evaluation accepts only when the resolved level is nonzero and strictly greater than cur_ipl. Acceptance shows as squash_req_o high for the cycle after the evaluating clock edge.
- R5: On acceptance, isr_o takes the summary mask and intid_o takes the level. Without acceptance both keep their previous values.
- R6: If irq_pend or blocked_o is high while pipe_empty is low, blocked_o is 1 after the edge. It stays 1 while the pipeline remains busy, even after irq_pend falls, and no evaluation takes place.
- R7: If irq_pend or blocked_o is high while pipe_empty is high and pc_lo is nonzero, blocked_o clears, nothing is accepted and nothing is written.
- R8: An evaluation with async_trap high raises async_err_o for one cycle. That evaluation accepts nothing and writes nothing.
- R9: A synchronous active-high rst clears blocked_o, squash_req_o, async_err_o, isr_o and intid_o.
- R10: With irq_pend and blocked_o both low, no evaluation occurs. squash_req_o and async_err_o stay low, whatever the request vectors hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_req | input | VEC_W | Pending software interrupt requests |
| ext_req | input | VEC_W | External interrupt lines |
| cur_ipl | input | LVL_W | Current interrupt priority level |
| async_trap | input | 1 | Asynchronous trap request (unsupported) |
| irq_pend | input | 1 | Pipeline control reports an interrupt pending |
| pipe_empty | input | 1 | No instructions remain in flight |
| pc_lo | input | 2 | Two low bits of the program counter |
| squash_req_o | output | 1 | One-cycle pulse: interrupt taken, squash the pipeline |
| isr_o | output | VEC_W | Interrupt summary register |
| intid_o | output | LVL_W | Interrupt ID register (accepted level) |
| blocked_o | output | 1 | Waiting for the pipeline to drain |
| async_err_o | output | 1 | One-cycle error pulse for an unsupported asynchronous trap |

## Verification
The bench drives the strict compare with a level equal to cur_ipl and with one just below it. A design that used >= would take the equal case. Requests outside the scan windows, such as software bit 0 or an external bit below EXT_MIN, must leave the level at zero. A design with wrong window bounds would report a level or set stray summary bits. The drain sequence drops irq_pend while the pipeline is still busy and then empties it. A resolver that did not hold the blocked flag would lose the interrupt, and one that ignored pc_lo would take an interrupt in privileged mode. A mix of software and external requests, together with an asynchronous trap, checks the override order and confirms that nothing is written on the error path.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

  // Outcome of the gate stage in one cycle
  typedef enum logic [1:0] {
    GATE_IDLE  = 2'd0,  // nothing signalled, nothing waiting
    GATE_HOLD  = 2'd1,  // pipeline busy: keep waiting
    GATE_DEFER = 2'd2,  // drained, privileged PC: drop this cycle
    GATE_EVAL  = 2'd3   // drained, normal PC: evaluate now
  } gate_e;

endpackage

// File: rtl/irq_scan.sv
module irq_scan #(
  parameter int VEC_W   = 32,
  parameter int LVL_W   = 5,
  parameter int SW_MIN  = 1,
  parameter int SW_MAX  = 16,
  parameter int EXT_MIN = 16,
  parameter int EXT_MAX = 32
) (
  input  logic [VEC_W-1:0] sw_req,
  input  logic [VEC_W-1:0] ext_req,
  output logic [LVL_W-1:0] level,
  output logic [VEC_W-1:0] summary,
  output logic             ext_any
);

  logic [VEC_W-1:0] sw_win;
  logic [VEC_W-1:0] ext_win;
  logic [VEC_W-1:0] sw_live;
  logic [VEC_W-1:0] ext_live;
  logic [LVL_W-1:0] sw_lvl;
  logic [LVL_W-1:0] ext_lvl;

  // Scan window masks, one bit per request position
  for (genvar g = 0; g < VEC_W; g++) begin : g_win
    assign sw_win[g]  = (g >= SW_MIN)  && (g < SW_MAX);
    assign ext_win[g] = (g >= EXT_MIN) && (g < EXT_MAX);
  end

  // Software bit i maps to i - SW_MIN + 1; last hit wins
  function automatic logic [LVL_W-1:0] sw_pick(input logic [VEC_W-1:0] v);
    logic [LVL_W-1:0] r;
    r = '0;
    for (int i = 0; i < VEC_W; i++)
      if (v[i]) r = LVL_W'(i - SW_MIN + 1);
    return r;
  endfunction

  // External bit i maps to level i; last hit wins
  function automatic logic [LVL_W-1:0] ext_pick(input logic [VEC_W-1:0] v);
    logic [LVL_W-1:0] r;
    r = '0;
    for (int i = 0; i < VEC_W; i++)
      if (v[i]) r = LVL_W'(i);
    return r;
  endfunction

  assign sw_live  = sw_req & sw_win;
  assign ext_live = ext_req & ext_win;
  assign sw_lvl   = sw_pick(sw_live);
  assign ext_lvl  = ext_pick(ext_live);
  assign ext_any  = |ext_live;
  assign level    = ext_any ? ext_lvl : sw_lvl;
  assign summary  = sw_live | ext_live;

endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_res_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       irq_pend,
  input  logic       pipe_empty,
  input  logic [1:0] pc_lo,
  output logic       blocked,
  output gate_e      decision
);

  logic blocked_q;

  always_comb begin
    if (!(irq_pend || blocked_q))   decision = GATE_IDLE;
    else if (!pipe_empty)           decision = GATE_HOLD;
    else if (pc_lo != 2'b00)        decision = GATE_DEFER;
    else                            decision = GATE_EVAL;
  end

  always_ff @(posedge clk) begin
    if (rst)
      blocked_q <= 1'b0;
    else if (decision == GATE_HOLD)
      blocked_q <= 1'b1;
    else if (decision != GATE_IDLE)
      blocked_q <= 1'b0;
  end

  assign blocked = blocked_q;

endmodule

// File: rtl/irq_accept.sv
module irq_accept #(
  parameter int VEC_W = 32,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             eval,
  input  logic             async_trap,
  input  logic [LVL_W-1:0] level,
  input  logic [VEC_W-1:0] summary,
  input  logic [LVL_W-1:0] cur_ipl,
  output logic             take,
  output logic             squash_q,
  output logic             err_q,
  output logic [VEC_W-1:0] isr_q,
  output logic [LVL_W-1:0] intid_q
);

  // Strict priority compare; a zero level never wins
  function automatic logic beats(input logic [LVL_W-1:0] lvl,
                                 input logic [LVL_W-1:0] ipl);
    return (lvl != '0) && (lvl > ipl);
  endfunction

  logic trap_hit;

  assign trap_hit = eval && async_trap;
  assign take     = eval && !async_trap && beats(level, cur_ipl);

  always_ff @(posedge clk) begin
    if (rst) begin
      squash_q <= 1'b0;
      err_q    <= 1'b0;
      isr_q    <= '0;
      intid_q  <= '0;
    end else begin
      squash_q <= take;
      err_q    <= trap_hit;
      if (take) begin
        isr_q   <= summary;
        intid_q <= level;
      end
    end
  end

endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
  import irq_res_pkg::*;
#(
  parameter int VEC_W   = 32,
  parameter int LVL_W   = 5,
  parameter int SW_MIN  = 1,
  parameter int SW_MAX  = 16,
  parameter int EXT_MIN = 16,
  parameter int EXT_MAX = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VEC_W-1:0] sw_req,
  input  logic [VEC_W-1:0] ext_req,
  input  logic [LVL_W-1:0] cur_ipl,
  input  logic             async_trap,
  input  logic             irq_pend,
  input  logic             pipe_empty,
  input  logic [1:0]       pc_lo,
  output logic             squash_req_o,
  output logic [VEC_W-1:0] isr_o,
  output logic [LVL_W-1:0] intid_o,
  output logic             blocked_o,
  output logic             async_err_o
);

  // Named internal events, visible to the checker
  logic [LVL_W-1:0] res_level;
  logic [VEC_W-1:0] res_summary;
  logic             res_ext_any;
  gate_e            gate_dec;
  logic             eval_now;
  logic             take_now;

  irq_scan #(
    .VEC_W(VEC_W), .LVL_W(LVL_W),
    .SW_MIN(SW_MIN), .SW_MAX(SW_MAX),
    .EXT_MIN(EXT_MIN), .EXT_MAX(EXT_MAX)
  ) u_scan (
    .sw_req  (sw_req),
    .ext_req (ext_req),
    .level   (res_level),
    .summary (res_summary),
    .ext_any (res_ext_any)
  );

  irq_gate u_gate (
    .clk        (clk),
    .rst        (rst),
    .irq_pend   (irq_pend),
    .pipe_empty (pipe_empty),
    .pc_lo      (pc_lo),
    .blocked    (blocked_o),
    .decision   (gate_dec)
  );

  assign eval_now = (gate_dec == GATE_EVAL);

  irq_accept #(.VEC_W(VEC_W), .LVL_W(LVL_W)) u_acc (
    .clk        (clk),
    .rst        (rst),
    .eval       (eval_now),
    .async_trap (async_trap),
    .level      (res_level),
    .summary    (res_summary),
    .cur_ipl    (cur_ipl),
    .take       (take_now),
    .squash_q   (squash_req_o),
    .err_q      (async_err_o),
    .isr_q      (isr_o),
    .intid_q    (intid_o)
  );

endmodule

// File: rtl/irq_level_resolver_chk.sv
module irq_level_resolver_chk #(
  parameter int VEC_W = 32,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [LVL_W-1:0] cur_ipl,
  input logic             irq_pend,
  input logic             pipe_empty,
  input logic [1:0]       pc_lo,
  input logic             squash_req_o,
  input logic [VEC_W-1:0] isr_o,
  input logic [LVL_W-1:0] intid_o,
  input logic             blocked_o,
  input logic             async_err_o
);

  // High once a full cycle out of reset has passed
  logic live_q;
  always_ff @(posedge clk) live_q <= !rst;

  // R4: a taken level beats the priority seen at the evaluating edge
  a_r4_above_ipl: assert property (@(posedge clk) disable iff (rst)
    live_q && squash_req_o |-> intid_o > $past(cur_ipl));

  // R5: the ID register never records a zero level on a take
  a_r5_nonzero_id: assert property (@(posedge clk) disable iff (rst)
    squash_req_o |-> intid_o != '0);

  // R5: status registers hold when nothing was taken
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    live_q && !squash_req_o |-> $stable(intid_o) && $stable(isr_o));

  // R6: busy pipeline keeps the request blocked
  a_r6_blocked: assert property (@(posedge clk) disable iff (rst)
    (irq_pend || blocked_o) && !pipe_empty |=> blocked_o && !squash_req_o);

  // R7: privileged PC on a drained pipeline defers
  a_r7_defer: assert property (@(posedge clk) disable iff (rst)
    (irq_pend || blocked_o) && pipe_empty && pc_lo != 2'b00
      |=> !blocked_o && !squash_req_o);

  // R8: an unsupported trap never coincides with a take
  a_r8_err_no_take: assert property (@(posedge clk) disable iff (rst)
    async_err_o |-> !squash_req_o);

  // R10: nothing signalled, nothing happens
  a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
    !irq_pend && !blocked_o |=> !squash_req_o && !async_err_o);

endmodule

bind irq_level_resolver irq_level_resolver_chk #(
  .VEC_W(VEC_W), .LVL_W(LVL_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cur_ipl      (cur_ipl),
  .irq_pend     (irq_pend),
  .pipe_empty   (pipe_empty),
  .pc_lo        (pc_lo),
  .squash_req_o (squash_req_o),
  .isr_o        (isr_o),
  .intid_o      (intid_o),
  .blocked_o    (blocked_o),
  .async_err_o  (async_err_o)
);

// File: tb/irq_level_resolver_tb.sv
module irq_level_resolver_tb;

  localparam int VEC_W = 32;
  localparam int LVL_W = 5;

  logic             clk = 1'b0;
  logic             rst;
  logic [VEC_W-1:0] sw_req;
  logic [VEC_W-1:0] ext_req;
  logic [LVL_W-1:0] cur_ipl;
  logic             async_trap;
  logic             irq_pend;
  logic             pipe_empty;
  logic [1:0]       pc_lo;
  logic             squash_req_o;
  logic [VEC_W-1:0] isr_o;
  logic [LVL_W-1:0] intid_o;
  logic             blocked_o;
  logic             async_err_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  irq_level_resolver u_dut (
    .clk(clk), .rst(rst), .sw_req(sw_req), .ext_req(ext_req),
    .cur_ipl(cur_ipl), .async_trap(async_trap), .irq_pend(irq_pend),
    .pipe_empty(pipe_empty), .pc_lo(pc_lo), .squash_req_o(squash_req_o),
    .isr_o(isr_o), .intid_o(intid_o), .blocked_o(blocked_o),
    .async_err_o(async_err_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Apply one cycle of stimulus, then sample after the edge
  task automatic step(input logic [31:0] sw, input logic [31:0] ex,
                      input int ipl, input logic pend, input logic pe,
                      input logic [1:0] pc, input logic at);
    @(negedge clk);
    sw_req = sw; ext_req = ex; cur_ipl = LVL_W'(ipl);
    irq_pend = pend; pipe_empty = pe; pc_lo = pc; async_trap = at;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(32'h0, 32'h0, 0, 1'b0, 1'b1, 2'b00, 1'b0);
    step(32'h0, 32'h0, 0, 1'b0, 1'b1, 2'b00, 1'b0);
    rst = 1'b0;
    chk("R9", "squash", 32'(squash_req_o), 32'd0);
    chk("R9", "blocked", 32'(blocked_o), 32'd0);
    chk("R9", "isr", isr_o, 32'd0);
    chk("R9", "intid", 32'(intid_o), 32'd0);
    chk("R9", "err", 32'(async_err_o), 32'd0);
  endtask

  task automatic t_software();
    // bits 3 and 7: level 7, summary 0x88
    step(32'h0000_0088, 32'h0, 2, 1'b1, 1'b1, 2'b00, 1'b0);
    chk("R1", "take", 32'(squash_req_o), 32'd1);
    chk("R1", "intid", 32'(intid_o), 32'd7);
    chk("R5", "isr", isr_o, 32'h0000_0088);
    step(32'h0, 32'h0, 0, 1'b0, 1'b1, 2'b00, 1'b0);
    chk("R4", "pulse ends", 32'(squash_req_o), 32'd0);
    chk("R5", "intid held", 32'(intid_o), 32'd7);
    chk("R5", "isr held", isr_o, 32'h0000_0088);
  endtask

  task automatic t_external();
    // sw bit 15 (level 15) loses to ext bits 18, 20 -> level 20
    step(32'h0000_8000, 32'h0014_0000, 19, 1'b1, 1'b1, 2'b00, 1'b0);
    chk("R2", "take", 32'(squash_req_o), 32'd1);
    chk("R2", "intid", 32'(intid_o), 32'd20);
    chk("R3", "isr", isr_o, 32'h0014_8000);
  endtask

  task automatic t_compare();
    step(32'h0, 32'h0010_0000, 20, 1'b1, 1'b1, 2'b00, 1'b0);
    chk("R4", "equal not taken", 32'(squash_req_o), 32'd0);
    step(32'h0, 32'h0010_0000, 21, 1'b1, 1'b1, 2'b00, 1'b0);
    chk("R4", "below not taken", 32'(squash_req_o), 32'd0);
    chk("R5", "intid unchanged", 32'(intid_o), 32'd20);
    step(32'h0, 32'h0010_0000, 19, 1'b1, 1'b1, 2'b00, 1'b0);
    chk("R4", "one above taken", 32'(squash_req_o), 32'd1);
  endtask

  task automatic t_windows();
    // sw bit 0 and ext bit 5 lie outside both windows
    step(32'h0000_0001, 32'h0000_0020, 0, 1'b1, 1'b1, 2'b00, 1'b0);
    chk("R3", "out of window no take", 32'(squash_req_o), 32'd0);
    step(32'h0000_0005, 32'h0000_0020, 0, 1'b1, 1'b1, 2'b00, 1'b0);
    chk("R3", "take", 32'(squash_req_o), 32'd1);
    chk("R1", "intid level 2", 32'(intid_o), 32'd2);
    chk("R3", "isr only in-window bit", isr_o, 32'h0000_0004);
  endtask

  task automatic t_drain();
    step(32'h0000_0010, 32'h0, 0, 1'b1, 1'b0, 2'b00, 1'b0);
    chk("R6", "blocked set", 32'(blocked_o), 32'd1);
    chk("R6", "no take while busy", 32'(squash_req_o), 32'd0);
    step(32'h0000_0010, 32'h0, 0, 1'b0, 1'b0, 2'b00, 1'b0);
    chk("R6", "blocked held", 32'(blocked_o), 32'd1);
    step(32'h0000_0010, 32'h0, 0, 1'b0, 1'b1, 2'b00, 1'b0);
    chk("R6", "taken after drain", 32'(squash_req_o), 32'd1);
    chk("R6", "intid 4", 32'(intid_o), 32'd4);
    chk("R6", "blocked cleared", 32'(blocked_o), 32'd0);
  endtask

  task automatic t_defer();
    step(32'h0000_0100, 32'h0, 0, 1'b1, 1'b0, 2'b00, 1'b0);
    chk("R6", "blocked set", 32'(blocked_o), 32'd1);
    step(32'h0000_0100, 32'h0, 0, 1'b0, 1'b1, 2'b10, 1'b0);
    chk("R7", "blocked cleared", 32'(blocked_o), 32'd0);
    chk("R7", "no take", 32'(squash_req_o), 32'd0);
    chk("R7", "intid unchanged", 32'(intid_o), 32'd4);
    step(32'h0000_0100, 32'h0, 0, 1'b0, 1'b1, 2'b00, 1'b0);
    chk("R10", "dropped request stays dropped", 32'(squash_req_o), 32'd0);
  endtask

  task automatic t_async();
    step(32'h0000_0020, 32'h0, 0, 1'b1, 1'b1, 2'b00, 1'b1);
    chk("R8", "err", 32'(async_err_o), 32'd1);
    chk("R8", "no take", 32'(squash_req_o), 32'd0);
    chk("R8", "intid unchanged", 32'(intid_o), 32'd4);
    step(32'h0, 32'h0, 0, 1'b0, 1'b1, 2'b00, 1'b0);
    chk("R8", "err pulse ends", 32'(async_err_o), 32'd0);
  endtask

  task automatic t_quiet();
    step(32'h0000_FFFE, 32'hFFFF_0000, 0, 1'b0, 1'b1, 2'b00, 1'b1);
    chk("R10", "no take", 32'(squash_req_o), 32'd0);
    chk("R10", "no err", 32'(async_err_o), 32'd0);
    chk("R10", "isr unchanged", isr_o, 32'h0000_0010);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected<=5000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    rst = 1'b1; sw_req = '0; ext_req = '0; cur_ipl = '0;
    async_trap = 1'b0; irq_pend = 1'b0; pipe_empty = 1'b1; pc_lo = 2'b00;
    t_reset();
    t_software();
    t_external();
    t_compare();
    t_windows();
    t_drain();
    t_defer();
    t_async();
    t_quiet();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule